// File: doc/BRIEF.md
# Paged Serial Register-Access Slave

This block lets an external serial controller read and write a paged on-chip register space. A transfer is framed by an active-low select. It opens with a 16-bit instruction that holds a direction flag and a 15-bit register address. One or more data bytes follow. While the select stays low after the first data byte, each further byte moves to the next address, stepping up or down as a control bit selects.

The lowest 32 addresses form a global window that every page shares. This window holds a control register, a scratch register that soft reset leaves alone, and a 64-bit page-select field. Page-backed storage sits above the window. This model backs four pages with 32 bytes each.

The block runs entirely on the serial clock. Input bits are captured on the rising edge and read data is launched on the falling edge. Read data returns on the shared data pin in 3-wire mode and on a dedicated output pin in 4-wire mode. The mode is chosen at runtime.

Top module: `spi_pg_top`

## Requirements
- R1: Raising `csn` ends the transfer and clears the bit count. The next transfer is decoded from its first bit. A data byte cut short by `csn` rising writes nothing.
- R2: Instruction bit 15 is 1 for a read and 0 for a write. Bits 14:0 are the address. The instruction and all data are sent MSB first, with one byte per register.
- R3: `sdio` is sampled on the rising edge of `sclk`. Read data changes only on the falling edge of `sclk`. The MSB of the first read byte is launched on the falling edge that follows the 16th rising edge.
- R4: In 3-wire mode (control bit 1 = 0), read data is driven on `sdio` only during the data phase of a read. Outside that phase `sdio` is released, and `sdo` stays 0 throughout.
- R5: In 4-wire mode (control bit 1 = 1), read data appears on `sdo` and the block never drives `sdio`.
- R6: With control bit 2 = 1, each completed byte in a transfer moves the address up by one.
- R7: With control bit 2 = 0, each completed byte in a transfer moves the address down by one.
- R8: Addresses 0x00–0x1F reach the same registers whatever page is selected. Unassigned global addresses read 0x00.
- R9: Page p is selected by bit p%8 of the register at 0x10+p/8, covering 0x10–0x17. When several bits are set, the lowest set bit wins.
- R10: Pages 0–3 each hold 32 bytes at 0x20–0x3F. Accesses to any other page, any address from 0x40 up, or any access while no page bit is set read 0x00 and ignore writes.
- R11: Writing 1 to control bit 0 returns the page-select field and all page storage to their reset values. The same write stores control bits 7:1. The control register and the scratch register at 0x01 are otherwise unchanged, and bit 0 always reads 0.
- R12: After `rst`, the control register reads 0x04 (3-wire, ascending), the scratch register reads 0x00, 0x10 reads 0x01 (page 0 selected), and all storage reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Active-low transfer select |
| sdio | inout | 1 | Serial data in; read data out in 3-wire mode |
| sdo | output | 1 | Read data out in 4-wire mode, 0 otherwise |

## Verification
The hardest state to reach from the ports is a page access while two page-select bits are set at once, or while no bit is set at all. Reaching it takes a write to a second select register, then a clear of the first, each followed by a read into the paged window. The vector table chains those steps so that each read shows which page, if any, is live. Soft reset is checked from inside 4-wire mode. This shows that the control write is kept while the page storage and selection fall back to their reset values.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;

    localparam int ADDR_W      = 15;
    localparam int DATA_W      = 8;
    localparam int INSTR_W     = ADDR_W + 1;
    localparam int NUM_PAGES   = 64;
    localparam int IMPL_PAGES  = 4;
    localparam int PAGE_SPAN   = 32;
    localparam int PSEL_BYTES  = NUM_PAGES / DATA_W;
    localparam int PAGE_IDX_W  = $clog2(NUM_PAGES);
    localparam int IMPL_IDX_W  = $clog2(IMPL_PAGES);
    localparam int OFF_W       = $clog2(PAGE_SPAN);
    localparam int PSEL_IW     = $clog2(PSEL_BYTES);
    localparam int BIT_W       = $clog2(DATA_W);
    localparam int ICNT_W      = $clog2(INSTR_W);

    localparam logic [ADDR_W-1:0] CTRL_ADDR    = 15'h0000;
    localparam logic [ADDR_W-1:0] SCRATCH_ADDR = 15'h0001;
    localparam logic [ADDR_W-1:0] PSEL_BASE    = 15'h0010;
    localparam logic [ADDR_W-1:0] PAGE_BASE    = 15'h0020;

    // control register bit positions
    localparam int CTRL_SOFT = 0;
    localparam int CTRL_FOUR = 1;
    localparam int CTRL_ASC  = 2;
    localparam logic [DATA_W-1:0] CTRL_RST = 8'h04;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic four_wire;
        logic ascend;
    } mode_t;

    typedef struct packed {
        logic                  hit;
        logic [PAGE_IDX_W-1:0] idx;
    } page_pick_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic up);
        return up ? a + 1'b1 : a - 1'b1;
    endfunction

    // lowest set bit wins
    function automatic page_pick_t pick_page(input logic [NUM_PAGES-1:0] v);
        page_pick_t r;
        r = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = PAGE_IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_pg_frame.sv
module spi_pg_frame
    import spi_pg_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              csn,
    input  logic              sdi,
    input  logic              ascend,
    output logic              in_data,
    output instr_t            cur,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);

    logic [ICNT_W-1:0]  icnt;
    logic [INSTR_W-2:0] sh;
    logic               byte_end;

    assign byte_end = (bit_idx == BIT_W'(DATA_W - 1));

    always_ff @(posedge sclk) begin
        if (rst || csn) begin
            icnt    <= '0;
            sh      <= '0;
            in_data <= 1'b0;
            bit_idx <= '0;
            cur     <= '0;
        end else begin
            sh <= {sh[INSTR_W-3:0], sdi};
            if (!in_data) begin
                icnt <= icnt + 1'b1;
                if (icnt == ICNT_W'(INSTR_W - 1)) begin
                    cur     <= instr_t'({sh, sdi});
                    in_data <= 1'b1;
                    bit_idx <= '0;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
                if (byte_end)
                    cur.addr <= step_addr(cur.addr, ascend);
            end
        end
    end

    // the last data bit lands in the same edge as the register write
    assign wr_en   = !csn && in_data && !cur.rd && byte_end;
    assign wr_data = {sh[DATA_W-2:0], sdi};

endmodule

// File: rtl/spi_pg_regs.sv
module spi_pg_regs
    import spi_pg_pkg::*;
(
    input  logic                 sclk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output mode_t                mode,
    output logic                 soft_pulse,
    output logic [NUM_PAGES-1:0] psel_flat
);

    logic [DATA_W-1:1] ctrl_q;
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] psel_q [PSEL_BYTES];
    logic [DATA_W-1:0] page_rd [IMPL_PAGES];
    page_pick_t        pick;

    function automatic logic in_psel(input logic [ADDR_W-1:0] a);
        return (a >= PSEL_BASE) && (a < PSEL_BASE + ADDR_W'(PSEL_BYTES));
    endfunction

    function automatic logic in_page(input logic [ADDR_W-1:0] a);
        return (a >= PAGE_BASE) && (a < PAGE_BASE + ADDR_W'(PAGE_SPAN));
    endfunction

    assign soft_pulse     = wr_en && (wr_addr == CTRL_ADDR) && wr_data[CTRL_SOFT];
    assign mode.four_wire = ctrl_q[CTRL_FOUR];
    assign mode.ascend    = ctrl_q[CTRL_ASC];
    assign pick           = pick_page(psel_flat);

    // control and scratch survive soft reset
    always_ff @(posedge sclk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST[DATA_W-1:1];
            scratch_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == CTRL_ADDR)    ctrl_q    <= wr_data[DATA_W-1:1];
            if (wr_addr == SCRATCH_ADDR) scratch_q <= wr_data;
        end
    end

    for (genvar b = 0; b < PSEL_BYTES; b++) begin : g_psel
        assign psel_flat[b*DATA_W +: DATA_W] = psel_q[b];
        always_ff @(posedge sclk) begin
            if (rst || soft_pulse)
                psel_q[b] <= (b == 0) ? DATA_W'(1) : '0;
            else if (wr_en && in_psel(wr_addr) && (wr_addr[PSEL_IW-1:0] == PSEL_IW'(b)))
                psel_q[b] <= wr_data;
        end
    end

    for (genvar p = 0; p < IMPL_PAGES; p++) begin : g_page
        logic [DATA_W-1:0] mem [PAGE_SPAN];
        logic              sel;
        assign sel        = pick.hit && (pick.idx == PAGE_IDX_W'(p));
        assign page_rd[p] = mem[rd_addr[OFF_W-1:0]];
        always_ff @(posedge sclk) begin
            if (rst || soft_pulse) begin
                for (int i = 0; i < PAGE_SPAN; i++) mem[i] <= '0;
            end else if (wr_en && sel && in_page(wr_addr)) begin
                mem[wr_addr[OFF_W-1:0]] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR)
            rd_data = {ctrl_q, 1'b0};
        else if (rd_addr == SCRATCH_ADDR)
            rd_data = scratch_q;
        else if (in_psel(rd_addr))
            rd_data = psel_q[rd_addr[PSEL_IW-1:0]];
        else if (in_page(rd_addr) && pick.hit && (pick.idx < PAGE_IDX_W'(IMPL_PAGES)))
            rd_data = page_rd[pick.idx[IMPL_IDX_W-1:0]];
    end

endmodule

// File: rtl/spi_pg_tx.sv
module spi_pg_tx
    import spi_pg_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              csn,
    input  logic              in_data,
    input  logic              rd_mode,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              four_wire,
    output logic              tx_bit,
    output logic              sdio_oe,
    output logic              sdo
);

    logic act_q;
    logic active;

    // launch on the falling edge, half a cycle after the capture edge
    always_ff @(negedge sclk) begin
        if (rst) begin
            act_q  <= 1'b0;
            tx_bit <= 1'b0;
        end else begin
            act_q  <= !csn && in_data && rd_mode;
            tx_bit <= rd_data[~bit_idx];
        end
    end

    assign active  = act_q && !csn;
    assign sdio_oe = active && !four_wire;
    assign sdo     = (active && four_wire) ? tx_bit : 1'b0;

endmodule

// File: rtl/spi_pg_top.sv
module spi_pg_top
    import spi_pg_pkg::*;
(
    input  logic sclk,
    input  logic rst,
    input  logic csn,
    inout  wire  sdio,
    output logic sdo
);

    logic                 sdi;
    logic                 in_data;
    instr_t               cur;
    logic [ADDR_W-1:0]    cur_addr;
    logic                 rd_mode;
    logic [BIT_W-1:0]     bit_idx;
    logic                 wr_en;
    logic [DATA_W-1:0]    wr_data;
    logic [DATA_W-1:0]    rd_data;
    mode_t                mode;
    logic                 soft_pulse;
    logic [NUM_PAGES-1:0] psel_flat;
    logic                 tx_bit;
    logic                 sdio_oe;

    assign sdi      = sdio;
    assign sdio     = sdio_oe ? tx_bit : 1'bz;
    assign cur_addr = cur.addr;
    assign rd_mode  = cur.rd;

    spi_pg_frame u_frame (
        .sclk    (sclk),
        .rst     (rst),
        .csn     (csn),
        .sdi     (sdi),
        .ascend  (mode.ascend),
        .in_data (in_data),
        .cur     (cur),
        .bit_idx (bit_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    spi_pg_regs u_regs (
        .sclk       (sclk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (cur_addr),
        .wr_data    (wr_data),
        .rd_addr    (cur_addr),
        .rd_data    (rd_data),
        .mode       (mode),
        .soft_pulse (soft_pulse),
        .psel_flat  (psel_flat)
    );

    spi_pg_tx u_tx (
        .sclk      (sclk),
        .rst       (rst),
        .csn       (csn),
        .in_data   (in_data),
        .rd_mode   (rd_mode),
        .bit_idx   (bit_idx),
        .rd_data   (rd_data),
        .four_wire (mode.four_wire),
        .tx_bit    (tx_bit),
        .sdio_oe   (sdio_oe),
        .sdo       (sdo)
    );

endmodule

// File: rtl/spi_pg_chk.sv
module spi_pg_chk
    import spi_pg_pkg::*;
(
    input logic                 sclk,
    input logic                 rst,
    input logic                 csn,
    input logic                 in_data,
    input logic [BIT_W-1:0]     bit_idx,
    input logic [ADDR_W-1:0]    cur_addr,
    input logic                 rd_mode,
    input mode_t                mode,
    input logic                 sdio_oe,
    input logic                 soft_pulse,
    input logic [NUM_PAGES-1:0] psel_flat
);

    assert_abort_clears_R1: assert property (@(posedge sclk) disable iff (rst)
        csn |=> (!in_data && bit_idx == '0));

    assert_step_up_R6: assert property (@(posedge sclk) disable iff (rst)
        (!csn && in_data && bit_idx == BIT_W'(DATA_W - 1) && mode.ascend)
        |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    assert_step_down_R7: assert property (@(posedge sclk) disable iff (rst)
        (!csn && in_data && bit_idx == BIT_W'(DATA_W - 1) && !mode.ascend)
        |=> (cur_addr == ADDR_W'($past(cur_addr) - 1'b1)));

    assert_shared_pin_window_R4: assert property (@(posedge sclk) disable iff (rst)
        sdio_oe |-> (!csn && in_data && rd_mode && !mode.four_wire));

    assert_four_wire_quiet_R5: assert property (@(posedge sclk) disable iff (rst)
        mode.four_wire |-> !sdio_oe);

    assert_soft_reset_sel_R11: assert property (@(posedge sclk) disable iff (rst)
        soft_pulse |=> (psel_flat == NUM_PAGES'(1)));

endmodule

bind spi_pg_top spi_pg_chk u_chk (
    .sclk       (sclk),
    .rst        (rst),
    .csn        (csn),
    .in_data    (in_data),
    .bit_idx    (bit_idx),
    .cur_addr   (cur_addr),
    .rd_mode    (rd_mode),
    .mode       (mode),
    .sdio_oe    (sdio_oe),
    .soft_pulse (soft_pulse),
    .psel_flat  (psel_flat)
);

// File: tb/tb_spi_pg_top.sv
`timescale 1ns/1ps
module tb_spi_pg_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csn = 1'b1;
    logic tb_en = 1'b0;
    logic tb_bit = 1'b0;
    logic fourw = 1'b0;
    logic sdo_seen = 1'b0;
    wire  sdio;
    logic sdo;
    int   tests = 0;
    int   fails = 0;

    assign sdio = tb_en ? tb_bit : 1'bz;

    always #2.5 clk = ~clk;

    spi_pg_top dut (
        .sclk (clk),
        .rst  (rst),
        .csn  (csn),
        .sdio (sdio),
        .sdo  (sdo)
    );

    // {read, addr[14:0], write data, expected read data}
    localparam int NVEC = 24;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8000_0004, 32'h8001_0000, 32'h8010_0001, 32'h0025_A500,
        32'h8025_00A5, 32'h0001_3C00, 32'h8001_003C, 32'h8005_0000,
        32'h0050_7700, 32'h8050_0000, 32'h0010_0200, 32'h8025_0000,
        32'h0025_5A00, 32'h8025_005A, 32'h8001_003C, 32'h8010_0002,
        32'h0011_0100, 32'h8025_005A, 32'h0010_0000, 32'h8025_0000,
        32'h0025_9900, 32'h0011_0000, 32'h0010_0100, 32'h8025_00A5
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            csn    = 1'b0;
            tb_en  = 1'b1;
            tb_bit = v[i];
            @(posedge clk);
            #1;
        end
    endtask

    task automatic end_frame();
        csn   = 1'b1;
        tb_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            csn    = 1'b0;
            tb_en  = fourw;
            tb_bit = 1'b0;
            @(posedge clk);
            #1;
            v[i] = fourw ? sdo : sdio;
            if (!fourw) sdo_seen = sdo_seen | sdo;
        end
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        send_bits({1'b0, a}, 16);
        send_bits({8'h00, d}, 8);
        end_frame();
        if (a == 15'h0000) fourw = d[1];
    endtask

    task automatic do_read(input logic [14:0] a, output logic [7:0] d);
        send_bits({1'b1, a}, 16);
        recv_byte(d);
        end_frame();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R1 actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r, r2, r3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R12 reset sdo", {7'b0, sdo}, 8'h00);

        // table: R2 R8 R9 R10 R12 (reset values, global mirror, page priority)
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][31]) begin
                do_read(VEC[k][30:16], r);
                chk($sformatf("R2/R8/R9/R10/R12 vector %0d", k), r, VEC[k][7:0]);
            end else begin
                do_write(VEC[k][30:16], VEC[k][15:8]);
            end
        end

        // R6: ascending stream write then stream read
        send_bits({1'b0, 15'h0030}, 16);
        send_bits(16'h0011, 8);
        send_bits(16'h0022, 8);
        send_bits(16'h0033, 8);
        end_frame();
        send_bits({1'b1, 15'h0030}, 16);
        recv_byte(r);
        recv_byte(r2);
        recv_byte(r3);
        end_frame();
        chk("R6 stream byte0", r, 8'h11);
        chk("R6 stream byte1", r2, 8'h22);
        chk("R6 stream byte2", r3, 8'h33);
        do_read(15'h0032, r);
        chk("R6 single 0x32", r, 8'h33);

        // R7: descending
        do_write(15'h0000, 8'h00);
        send_bits({1'b0, 15'h003A}, 16);
        send_bits(16'h0044, 8);
        send_bits(16'h0055, 8);
        end_frame();
        do_read(15'h0039, r);
        chk("R7 single 0x39", r, 8'h55);
        send_bits({1'b1, 15'h003A}, 16);
        recv_byte(r);
        recv_byte(r2);
        end_frame();
        chk("R7 stream byte0", r, 8'h44);
        chk("R7 stream byte1", r2, 8'h55);
        chk("R4 sdo quiet in 3-wire", {7'b0, sdo_seen}, 8'h00);

        // R5 / R3: 4-wire, data on sdo
        do_write(15'h0000, 8'h06);
        do_read(15'h0030, r);
        chk("R5 R3 4-wire read", r, 8'h11);
        do_read(15'h0000, r);
        chk("R5 ctrl readback", r, 8'h06);

        // R1: aborted instruction and aborted data byte
        send_bits(16'h0000, 8);
        end_frame();
        send_bits({1'b0, 15'h0022}, 16);
        send_bits(16'h000F, 4);
        end_frame();
        do_read(15'h0022, r);
        chk("R1 partial byte not written", r, 8'h00);
        do_read(15'h0030, r);
        chk("R1 framing recovered", r, 8'h11);

        // R11: soft reset
        do_write(15'h0000, 8'h07);
        do_read(15'h0000, r);
        chk("R11 ctrl kept, bit0 clear", r, 8'h06);
        do_read(15'h0001, r);
        chk("R11 scratch kept", r, 8'h3C);
        do_read(15'h0030, r);
        chk("R11 storage cleared", r, 8'h00);
        do_read(15'h0010, r);
        chk("R11 page select default", r, 8'h01);

        // R4: back to 3-wire
        do_write(15'h0000, 8'h04);
        do_read(15'h0001, r);
        chk("R4 3-wire read", r, 8'h3C);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule